// File: doc/BRIEF.md
# Bit-Serial Distributed Arithmetic Dot Product

This block forms the weighted sum of three signed input words with three fixed coefficients, and it uses no multiplier. A one-cycle start strobe captures all three inputs at once. After that, the block walks through their bit positions one per clock, least significant first. In each cycle the current bit of every input is gathered into a small address. That address selects a precomputed sum of the coefficient subset it names. The selected value is added into an accumulator that shifts right arithmetically every cycle. In the final cycle the sign bit is processed, and there the value is subtracted, because the sign bit of a two's-complement word carries negative weight.

The accumulator has fixed-point format: its low `DATA_W-1` bits are the fraction. The final register contents, read as a plain signed integer, equal the exact dot product. A control state machine has two states, `ST_IDLE` and `ST_RUN`, and four transitions:
- **accept**: `ST_IDLE`→`ST_RUN` on start.
- **wait**: `ST_IDLE`→`ST_IDLE` without start.
- **step**: `ST_RUN`→`ST_RUN` while bits remain.
- **finish**: `ST_RUN`→`ST_IDLE` on the sign bit.

A finished result stays on the accumulator port until the next accepted start.

Top module: `dadp_top`

## Requirements
- R1: After reset, `acc` reads 0 and `done` reads 0.
- R2: Input k occupies bits [4k+3:4k] of `x_flat`. The table address in a cycle is {bit of x2, bit of x1, bit of x0}. The table value is the sum of the coefficients whose address bit is set, with c0=3, c1=-1, c2=5. The values for addresses 0..7 are therefore 0, 3, -1, 2, 5, 8, 4, 7.
- R3: Exactly one bit position is consumed per cycle, starting with the LSB. Each cycle the accumulator becomes its arithmetic right shift plus the table value placed at bit 3. For x0=-6, x1=2, x2=-5 the four successive `acc` values are 40, 76, 38 and -45.
- R4: In the fourth (sign-bit) cycle the table value is subtracted instead of added.
- R5: For every combination of signed 4-bit inputs, the final `acc`, read as a 9-bit signed integer, equals 3·x0 − x1 + 5·x2.
- R6: An accepted start captures the inputs and clears `acc` to 0 on the same edge.
- R7: `done` is high for exactly one cycle, starting at the edge that writes the final result. That edge is the fourth edge after the start edge.
- R8: A start that arrives while a computation is running, including in its last cycle, is ignored. The result and the `done` timing are those of the running operands.
- R9: A start that is present in the cycle `done` is high is accepted.
- R10: While idle with no start, `acc` holds its value regardless of `x_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin when idle |
| x_flat | input | 12 | Three signed 4-bit inputs, x0 in the low nibble |
| done | output | 1 | One-cycle pulse marking the final result |
| acc | output | 9 | Signed accumulator, 3 fraction bits; final value equals the dot product |

## Verification
Two functions can land on the same edge: a new start request, and the sign-bit subtraction that finishes a run. The bench provokes this collision in three ways. It raises start mid-run. It raises start exactly in the sign-bit cycle. It raises start in the cycle that follows, while `done` is high. In the first two cases the result must be the old operands' product, and `acc` must not be cleared one cycle later. In the third case `acc` must read 0 right after the edge, and the new product must follow four edges later.

// File: rtl/dadp_pkg.sv
`timescale 1ns/1ps
package dadp_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dadp_state_e;
endpackage

// File: rtl/dadp_lut.sv
`timescale 1ns/1ps
module dadp_lut #(
    parameter int K      = 3,
    parameter int COEF_W = 5,
    parameter int VAL_W  = 6,
    parameter logic [K*COEF_W-1:0] COEFS = '0
) (
    input  logic [K-1:0]            addr,
    output logic signed [VAL_W-1:0] value
);
    localparam int DEPTH = 1 << K;

    logic signed [VAL_W-1:0] tbl [DEPTH];

    // every subset sum of the coefficients, one entry per address
    always_comb begin
        for (int a = 0; a < DEPTH; a++) begin
            tbl[a] = '0;
            for (int k = 0; k < K; k++) begin
                if (((a >> k) & 1) == 1) begin
                    tbl[a] = tbl[a] + VAL_W'($signed(COEFS[k*COEF_W +: COEF_W]));
                end
            end
        end
    end

    assign value = tbl[addr];
endmodule

// File: rtl/dadp_shreg.sv
`timescale 1ns/1ps
module dadp_shreg #(
    parameter int K      = 3,
    parameter int DATA_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [K*DATA_W-1:0] x_flat,
    output logic [K-1:0]        bits
);
    for (genvar k = 0; k < K; k++) begin : g_lane
        logic [DATA_W-1:0] sr_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sr_q <= '0;
            end else if (load) begin
                sr_q <= x_flat[k*DATA_W +: DATA_W];
            end else if (shift) begin
                sr_q <= sr_q >> 1;
            end
        end

        assign bits[k] = sr_q[0];
    end
endmodule

// File: rtl/dadp_ctrl.sv
`timescale 1ns/1ps
module dadp_ctrl
    import dadp_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic done
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    dadp_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= last;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (cnt_q == LAST_BIT) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        last = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                last = (cnt_q == LAST_BIT);
            end
            default: ;
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/dadp_top.sv
`timescale 1ns/1ps
module dadp_top #(
    parameter int K      = 3,
    parameter int DATA_W = 4,
    parameter int COEF_W = 5,
    parameter int INT_W  = 6,
    parameter logic [K*COEF_W-1:0] COEFS = {5'd5, 5'h1F, 5'd3}
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [K*DATA_W-1:0]               x_flat,
    output logic                              done,
    output logic signed [INT_W+DATA_W-2:0]    acc
);
    localparam int FRAC_W = DATA_W - 1;
    localparam int ACC_W  = INT_W + FRAC_W;

    logic                    load, step, last;
    logic [K-1:0]            addr;
    logic signed [INT_W-1:0] lut_val;
    logic signed [ACC_W-1:0] acc_q, acc_d, term;

    dadp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .done  (done)
    );

    dadp_shreg #(.K(K), .DATA_W(DATA_W)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .shift  (step),
        .x_flat (x_flat),
        .bits   (addr)
    );

    dadp_lut #(.K(K), .COEF_W(COEF_W), .VAL_W(INT_W), .COEFS(COEFS)) u_lut (
        .addr  (addr),
        .value (lut_val)
    );

    // table value aligned to the binary point; negated on the sign bit
    always_comb begin
        term = ACC_W'(lut_val) <<< FRAC_W;
        if (last) begin
            acc_d = (acc_q >>> 1) - term;
        end else begin
            acc_d = (acc_q >>> 1) + term;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/dadp_chk.sv
`timescale 1ns/1ps
module dadp_chk #(
    parameter int DATA_W = 4,
    parameter int ACC_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [ACC_W-1:0] acc
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    // independent model of the busy window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            if (start) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end
        end else if (cnt_q == LAST_BIT) begin
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !run_q) |=> (acc == '0)); // R6

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == LAST_BIT) |=> done); // R7

    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_q && cnt_q == LAST_BIT) |=> !done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start) |=> $stable(acc)); // R10
endmodule

bind dadp_top dadp_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .acc   (acc_q)
);

// File: tb/dadp_top_test.sv
`timescale 1ns/1ps
module dadp_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] x_flat = '0;
    logic        done;
    logic signed [8:0] acc;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    dadp_top uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_flat (x_flat),
        .done   (done),
        .acc    (acc)
    );

    function automatic int expect_dot(input int a, input int b, input int c);
        return 3 * a - b + 5 * c;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic set_x(input int a, input int b, input int c);
        x_flat = {4'(c), 4'(b), 4'(a)};
    endtask

    // raise start for one edge; returns just after the accepting edge
    task automatic launch(input int a, input int b, input int c);
        @(negedge clk);
        set_x(a, b, c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic op(input int a, input int b, input int c, input string tag);
        launch(a, b, c);
        chk("R6 acc cleared on start", int'(acc), 0);
        repeat (3) @(negedge clk);
        chk("R7 no early done", int'(done), 0);
        @(negedge clk);
        chk("R7 done on fourth edge", int'(done), 1);
        chk(tag, int'(acc), expect_dot(a, b, c));
        @(negedge clk);
        chk("R7 done falls", int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 acc at reset", int'(acc), 0);
        chk("R1 done at reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 acc after release", int'(acc), 0);
        chk("R1 done after release", int'(done), 0);
    endtask

    task automatic t_table();
        for (int a = 0; a < 8; a++) begin
            op(a & 1, (a >> 1) & 1, (a >> 2) & 1, "R2 table entry");
        end
    endtask

    task automatic t_trace();
        launch(-6, 2, -5);
        @(negedge clk);
        chk("R3 step0", int'(acc), 40);
        @(negedge clk);
        chk("R3 step1", int'(acc), 76);
        @(negedge clk);
        chk("R3 step2", int'(acc), 38);
        @(negedge clk);
        chk("R3 step3", int'(acc), -45);
        chk("R3 done", int'(done), 1);
        @(negedge clk);
    endtask

    task automatic t_sign();
        op(-8, 0, 0, "R4 sign bit x0");
        op(0, -8, 0, "R4 sign bit x1");
        op(-8, 7, -8, "R4 most negative");
        op(7, -8, 7, "R4 most positive");
    endtask

    task automatic t_all();
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                for (int c = -8; c < 8; c++) begin
                    op(a, b, c, "R5 exhaustive");
                end
            end
        end
    endtask

    task automatic t_busy_mid();
        launch(1, 2, 3);
        @(negedge clk);
        set_x(-8, -8, -8);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R8 mid start no early done", int'(done), 0);
        @(negedge clk);
        chk("R8 mid start done", int'(done), 1);
        chk("R8 mid start result", int'(acc), 16);
        @(negedge clk);
        chk("R8 mid start held", int'(acc), 16);
        chk("R8 mid start done low", int'(done), 0);
    endtask

    task automatic t_busy_last();
        launch(7, 0, 7);
        repeat (3) @(negedge clk);
        set_x(1, 1, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 last start done", int'(done), 1);
        chk("R8 last start result", int'(acc), 56);
        @(negedge clk);
        chk("R8 last start not cleared", int'(acc), 56);
        repeat (4) @(negedge clk);
        chk("R8 last start no second done", int'(done), 0);
        chk("R8 last start still held", int'(acc), 56);
    endtask

    task automatic t_back2back();
        launch(2, 1, 0);
        repeat (4) @(negedge clk);
        chk("R9 first done", int'(done), 1);
        chk("R9 first result", int'(acc), 5);
        set_x(-1, -1, -1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 accepted clears", int'(acc), 0);
        repeat (4) @(negedge clk);
        chk("R9 second done", int'(done), 1);
        chk("R9 second result", int'(acc), -7);
        @(negedge clk);
    endtask

    task automatic t_hold();
        op(3, -4, 5, "R10 setup");
        set_x(-8, 7, -8);
        repeat (5) @(negedge clk);
        chk("R10 held value", int'(acc), expect_dot(3, -4, 5));
        chk("R10 no done", int'(done), 0);
    endtask

    initial begin
        t_reset();
        t_table();
        t_trace();
        t_sign();
        t_busy_mid();
        t_busy_last();
        t_back2back();
        t_hold();
        t_all();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule